// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block supplies the byte that an 8-input interrupt controller places on the processor data bus while the processor acknowledges an interrupt. It counts the acknowledge strobes of one acknowledge sequence. For each strobe it picks the byte to present, decides whether the bus driver is enabled, and drives the cascade code that tells downstream controllers which input is being served. Priority resolution and the programming of the base values happen elsewhere. This block receives the resolved interrupt number and the programmed base fields as inputs.

Two processor families are supported, chosen by a mode input. In the 8-bit mode a sequence has three strobes: a subroutine-call opcode, a low address byte, and a high address byte. The low address byte places the interrupt number at a stride of 4 or 8 bytes. In the 16-bit mode a sequence has two strobes. The first one delivers no data. It only freezes the interrupt number and issues the cascade code. The second one delivers a type byte formed from a programmed base and the interrupt number. The mode and the interrupt number are captured on the first strobe of a sequence and held until the sequence ends. An initialization command returns the sequence to its first strobe.

Top module: `iack_vector_gen`

## Requirements
- R1: After a synchronous reset, `data_oe`, `data_out`, `casc_out` and `freeze` are all 0, and the next strobe is treated as the first strobe of a sequence.
- R2: In 8-bit mode (`mode16`=0), the first strobe drives byte 0xCD with `data_oe`=1.
- R3: In 8-bit mode with `interval4`=1, the second strobe drives {`lo_base`[7:5], irq[2:0], 2'b00}.
- R4: In 8-bit mode with `interval4`=0, the second strobe drives {`lo_base`[7:6], irq[2:0], 3'b000}.
- R5: In 8-bit mode, the third strobe drives `hi_base`[7:0]. The strobe after it is again a first strobe.
- R6: In 16-bit mode (`mode16`=1), the first strobe keeps `data_oe` at 0 and raises `freeze` for exactly one clock, one clock after the strobe rises.
- R7: In 16-bit mode, the second strobe drives {`type_base`[7:3], irq[2:0]} whatever the value of `interval4`. The strobe after it is again a first strobe.
- R8: The interrupt number and the mode are sampled on the first strobe. Changes to `irq_num` or `mode16` during the rest of the sequence have no effect on the bytes delivered.
- R9: When `casc_en`=1 and `is_slave`=0 (master), `casc_out` takes the sampled interrupt number one clock after the first strobe rises. It holds that value until one clock after the last strobe of the sequence falls, and is then 0. When not a master, `casc_out` stays 0.
- R10: When `casc_en`=1 and `is_slave`=1, `data_oe` is raised only on strobes after the first, and only while `casc_in` equals `slave_id`.
- R11: A one-clock `init_cmd` pulse returns the sequence to its first strobe and clears `data_oe` and `casc_out`.
- R12: `data_oe` rises one clock after `ack` rises and falls one clock after `ack` falls. It is never 1 in a clock whose previous `ack` sample was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_cmd | input | 1 | Initialization command seen; restarts the sequence |
| ack | input | 1 | Acknowledge strobe, active high |
| irq_num | input | 3 | Resolved interrupt number |
| mode16 | input | 1 | 1 = 16-bit processor mode, 0 = 8-bit mode |
| interval4 | input | 1 | 1 = 4-byte address stride, 0 = 8-byte stride (8-bit mode only) |
| lo_base | input | 8 | Programmed low address bits (upper bits used) |
| hi_base | input | 8 | Programmed high address byte |
| type_base | input | 8 | Programmed type base (bits 7:3 used) |
| casc_en | input | 1 | Cascading enabled |
| is_slave | input | 1 | 1 = this controller is a slave |
| slave_id | input | 3 | Identity of this controller as a slave |
| casc_in | input | 3 | Cascade code received from the master |
| data_out | output | 8 | Byte for the data bus |
| data_oe | output | 1 | Data bus output enable |
| casc_out | output | 3 | Cascade code driven as master |
| freeze | output | 1 | One-clock pulse when pending requests are frozen |

## Verification
The hardest situation to reach is a sequence whose inputs move partway through. The mode flips from 8-bit to 16-bit after the first strobe, or the interrupt number changes between strobes. The stimulus changes `mode16` and `irq_num` between strobes of a running sequence and expects the bytes of the mode and number that were sampled at the start. A second hard case is an initialization command that arrives in the middle of a sequence. The bench issues one after a single 8-bit strobe and expects the call opcode again on the next strobe.

// File: rtl/iack_pkg.sv
package iack_pkg;

  typedef enum logic [1:0] {
    CYC_FIRST  = 2'd0,
    CYC_SECOND = 2'd1,
    CYC_THIRD  = 2'd2
  } ack_cyc_e;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;

endpackage

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_cmd,
  input  logic             ack,
  input  logic             mode16,
  input  logic [IRQ_W-1:0] irq_num,
  output logic             rise,
  output logic             first_rise,
  output logic             last_fall,
  output ack_cyc_e         cyc,
  output logic             cur_mode16,
  output logic [IRQ_W-1:0] cur_irq
);

  logic             ack_q;
  ack_cyc_e         cyc_q;
  logic             mode_frz;
  logic [IRQ_W-1:0] irq_frz;
  logic             fall;
  logic             is_last;

  assign rise       = ack & ~ack_q;
  assign fall       = ~ack & ack_q;
  assign cyc        = cyc_q;
  assign cur_mode16 = (cyc_q == CYC_FIRST) ? mode16  : mode_frz;
  assign cur_irq    = (cyc_q == CYC_FIRST) ? irq_num : irq_frz;
  assign is_last    = cur_mode16 ? (cyc_q == CYC_SECOND) : (cyc_q == CYC_THIRD);
  assign first_rise = rise & (cyc_q == CYC_FIRST);
  assign last_fall  = fall & is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      cyc_q    <= CYC_FIRST;
      mode_frz <= 1'b0;
      irq_frz  <= '0;
    end else begin
      ack_q <= ack;
      if (init_cmd) begin
        cyc_q <= CYC_FIRST;
      end else begin
        if (first_rise) begin
          mode_frz <= mode16;
          irq_frz  <= irq_num;
        end
        if (fall) begin
          if (is_last) begin
            cyc_q <= CYC_FIRST;
          end else begin
            unique case (cyc_q)
              CYC_FIRST:  cyc_q <= CYC_SECOND;
              CYC_SECOND: cyc_q <= CYC_THIRD;
              default:    cyc_q <= CYC_FIRST;
            endcase
          end
        end
      end
    end
  end

  AST_CYC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cyc_q != 2'd3); // R5

  AST_MODE16_TWO_CYC: assert property (@(posedge clk) disable iff (rst)
    (mode_frz && cyc_q != CYC_FIRST) |-> cyc_q == CYC_SECOND); // R7

  AST_FROZEN_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (cyc_q != CYC_FIRST && $past(cyc_q) != CYC_FIRST && !$past(init_cmd) && !$past(rst))
      |-> $stable(irq_frz)); // R8

endmodule

// File: rtl/iack_byte.sv
module iack_byte
  import iack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IRQ_W = 3
) (
  input  ack_cyc_e         cyc,
  input  logic             mode16,
  input  logic             interval4,
  input  logic [IRQ_W-1:0] irq,
  input  logic [DW-1:0]    lo_base,
  input  logic [DW-1:0]    hi_base,
  input  logic [DW-1:0]    type_base,
  output logic [DW-1:0]    byte_out,
  output logic             deliver
);

  localparam int LO4_LSB = IRQ_W + 2;
  localparam int LO8_LSB = IRQ_W + 3;

  logic [DW-1:0] lo_byte4;
  logic [DW-1:0] lo_byte8;
  logic [DW-1:0] type_byte;

  generate
    if (DW > LO4_LSB) begin : g_lo4
      assign lo_byte4 = {lo_base[DW-1:LO4_LSB], irq, 2'b00};
    end else begin : g_lo4_none
      assign lo_byte4 = DW'({irq, 2'b00});
    end
    if (DW > LO8_LSB) begin : g_lo8
      assign lo_byte8 = {lo_base[DW-1:LO8_LSB], irq, 3'b000};
    end else begin : g_lo8_none
      assign lo_byte8 = DW'({irq, 3'b000});
    end
  endgenerate

  assign type_byte = {type_base[DW-1:IRQ_W], irq};

  always_comb begin
    byte_out = '0;
    deliver  = 1'b0;
    if (mode16) begin
      if (cyc == CYC_SECOND) begin
        byte_out = type_byte;
        deliver  = 1'b1;
      end
    end else begin
      unique case (cyc)
        CYC_FIRST: begin
          byte_out = DW'(CALL_OPCODE);
          deliver  = 1'b1;
        end
        CYC_SECOND: begin
          byte_out = interval4 ? lo_byte4 : lo_byte8;
          deliver  = 1'b1;
        end
        CYC_THIRD: begin
          byte_out = hi_base;
          deliver  = 1'b1;
        end
        default: begin
          byte_out = '0;
          deliver  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/iack_casc.sv
module iack_casc
  import iack_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_cmd,
  input  logic             casc_en,
  input  logic             is_slave,
  input  logic [IRQ_W-1:0] slave_id,
  input  logic [IRQ_W-1:0] casc_in,
  input  logic             first_rise,
  input  logic             last_fall,
  input  logic [IRQ_W-1:0] cur_irq,
  input  ack_cyc_e         cyc,
  output logic [IRQ_W-1:0] casc_out,
  output logic             bus_allowed
);

  logic             master;
  logic             slave;
  logic             id_match;
  logic [IRQ_W-1:0] casc_q;

  assign master = casc_en & ~is_slave;
  assign slave  = casc_en & is_slave;

  generate
    for (genvar b = 0; b < 1; b++) begin : g_cmp
      assign id_match = (casc_in == slave_id);
    end
  endgenerate

  assign bus_allowed = ~slave | (id_match & (cyc != CYC_FIRST));
  assign casc_out    = casc_q;

  always_ff @(posedge clk) begin
    if (rst || init_cmd) begin
      casc_q <= '0;
    end else if (first_rise) begin
      casc_q <= master ? cur_irq : '0;
    end else if (last_fall) begin
      casc_q <= '0;
    end
  end

  AST_CASC_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(first_rise) && !$past(init_cmd) && !$past(rst))
      |-> casc_q == ($past(master) ? $past(cur_irq) : '0)); // R9

endmodule

// File: rtl/iack_vector_gen.sv
module iack_vector_gen
  import iack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_cmd,
  input  logic             ack,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic             mode16,
  input  logic             interval4,
  input  logic [DW-1:0]    lo_base,
  input  logic [DW-1:0]    hi_base,
  input  logic [DW-1:0]    type_base,
  input  logic             casc_en,
  input  logic             is_slave,
  input  logic [IRQ_W-1:0] slave_id,
  input  logic [IRQ_W-1:0] casc_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic [IRQ_W-1:0] casc_out,
  output logic             freeze
);

  logic             rise;
  logic             first_rise;
  logic             last_fall;
  ack_cyc_e         cyc;
  logic             cur_mode16;
  logic [IRQ_W-1:0] cur_irq;
  logic [DW-1:0]    byte_sel;
  logic             deliver;
  logic             bus_allowed;

  iack_seq #(.IRQ_W(IRQ_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .init_cmd   (init_cmd),
    .ack        (ack),
    .mode16     (mode16),
    .irq_num    (irq_num),
    .rise       (rise),
    .first_rise (first_rise),
    .last_fall  (last_fall),
    .cyc        (cyc),
    .cur_mode16 (cur_mode16),
    .cur_irq    (cur_irq)
  );

  iack_byte #(.DW(DW), .IRQ_W(IRQ_W)) u_byte (
    .cyc       (cyc),
    .mode16    (cur_mode16),
    .interval4 (interval4),
    .irq       (cur_irq),
    .lo_base   (lo_base),
    .hi_base   (hi_base),
    .type_base (type_base),
    .byte_out  (byte_sel),
    .deliver   (deliver)
  );

  iack_casc #(.IRQ_W(IRQ_W)) u_casc (
    .clk         (clk),
    .rst         (rst),
    .init_cmd    (init_cmd),
    .casc_en     (casc_en),
    .is_slave    (is_slave),
    .slave_id    (slave_id),
    .casc_in     (casc_in),
    .first_rise  (first_rise),
    .last_fall   (last_fall),
    .cur_irq     (cur_irq),
    .cyc         (cyc),
    .casc_out    (casc_out),
    .bus_allowed (bus_allowed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
      freeze   <= 1'b0;
    end else if (init_cmd) begin
      data_oe  <= 1'b0;
      freeze   <= 1'b0;
    end else begin
      if (rise) begin
        data_out <= byte_sel;
      end
      data_oe <= ack & deliver & bus_allowed;
      freeze  <= first_rise;
    end
  end

  AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(ack)); // R12

  AST_FREEZE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    freeze |=> !freeze); // R6

  AST_NO_OE_16_FIRST: assert property (@(posedge clk) disable iff (rst)
    (first_rise && mode16 && !init_cmd) |=> !data_oe); // R6

  AST_SLAVE_ID_GATE: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(casc_en && is_slave)) |-> $past(casc_in) == $past(slave_id)); // R10

endmodule

// File: tb/iack_vector_gen_tb.sv
module iack_vector_gen_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       init_cmd;
  logic       ack;
  logic [2:0] irq_num;
  logic       mode16;
  logic       interval4;
  logic [7:0] lo_base;
  logic [7:0] hi_base;
  logic [7:0] type_base;
  logic       casc_en;
  logic       is_slave;
  logic [2:0] slave_id;
  logic [2:0] casc_in;
  logic [7:0] data_out;
  logic       data_oe;
  logic [2:0] casc_out;
  logic       freeze;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] p_data;
  logic       p_oe;
  logic       p_frz;
  logic [2:0] p_casc;
  logic       p_oe_after;
  logic       p_frz_after;
  logic [2:0] p_casc_after;

  always #4 clk = ~clk;

  iack_vector_gen u_dut (
    .clk(clk), .rst(rst), .init_cmd(init_cmd), .ack(ack), .irq_num(irq_num),
    .mode16(mode16), .interval4(interval4), .lo_base(lo_base), .hi_base(hi_base),
    .type_base(type_base), .casc_en(casc_en), .is_slave(is_slave),
    .slave_id(slave_id), .casc_in(casc_in), .data_out(data_out),
    .data_oe(data_oe), .casc_out(casc_out), .freeze(freeze)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one strobe: raise at a falling edge, hold two clocks, drop, observe
  task automatic pulse();
    @(negedge clk) ack = 1'b1;
    @(negedge clk);
    p_data = data_out; p_oe = data_oe; p_frz = freeze; p_casc = casc_out;
    @(negedge clk) ack = 1'b0;
    @(negedge clk);
    p_oe_after = data_oe; p_frz_after = freeze; p_casc_after = casc_out;
  endtask

  task automatic do_reset();
    rst = 1'b1; init_cmd = 1'b0; ack = 1'b0; irq_num = '0; mode16 = 1'b0;
    interval4 = 1'b1; lo_base = 8'h00; hi_base = 8'h00; type_base = 8'h00;
    casc_en = 1'b0; is_slave = 1'b0; slave_id = '0; casc_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 data_oe", data_oe, 0);
    chk("R1 data_out", data_out, 0);
    chk("R1 casc_out", casc_out, 0);
    chk("R1 freeze", freeze, 0);
  endtask

  task automatic t_8bit_int4();
    mode16 = 0; interval4 = 1; lo_base = 8'hA0; hi_base = 8'h3C; irq_num = 3'd6;
    pulse();
    chk("R2 call opcode", p_data, 8'hCD);
    chk("R2 oe", p_oe, 1);
    chk("R12 oe falls after ack", p_oe_after, 0);
    pulse();
    chk("R3 interval4 byte", p_data, 8'hB8);
    chk("R3 oe", p_oe, 1);
    pulse();
    chk("R5 high byte", p_data, 8'h3C);
    chk("R5 oe", p_oe, 1);
    pulse();
    chk("R5 restart call opcode", p_data, 8'hCD);
    pulse(); pulse();
  endtask

  task automatic t_8bit_int8();
    mode16 = 0; interval4 = 0; lo_base = 8'hC0; hi_base = 8'h12; irq_num = 3'd5;
    pulse();
    chk("R2 call opcode int8", p_data, 8'hCD);
    irq_num = 3'd2;
    pulse();
    chk("R4 interval8 byte", p_data, 8'hE8);
    chk("R8 irq change ignored", p_data, 8'hE8);
    pulse();
    chk("R5 high byte int8", p_data, 8'h12);
  endtask

  task automatic t_16bit();
    mode16 = 1; type_base = 8'h48; irq_num = 3'd3; interval4 = 1;
    pulse();
    chk("R6 oe low first", p_oe, 0);
    chk("R6 freeze pulse", p_frz, 1);
    chk("R6 freeze one clock", p_frz_after, 0);
    interval4 = 0; irq_num = 3'd7;
    pulse();
    chk("R7 type byte", p_data, 8'h4B);
    chk("R7 oe", p_oe, 1);
    chk("R6 no freeze second", p_frz, 0);
    pulse();
    chk("R7 restart oe low", p_oe, 0);
    chk("R7 restart freeze", p_frz, 1);
    irq_num = 3'd1; interval4 = 1;
    pulse();
    chk("R7 type byte interval ignored", p_data, 8'h4F);
  endtask

  task automatic t_mode_change();
    mode16 = 0; interval4 = 1; lo_base = 8'h20; hi_base = 8'h99; irq_num = 3'd1;
    pulse();
    chk("R2 call before mode change", p_data, 8'hCD);
    mode16 = 1;
    pulse();
    chk("R8 mode frozen second", p_data, 8'h24);
    pulse();
    chk("R8 mode frozen third", p_data, 8'h99);
    chk("R8 third oe", p_oe, 1);
    mode16 = 0;
  endtask

  task automatic t_master();
    casc_en = 1; is_slave = 0; mode16 = 0; irq_num = 3'd5;
    pulse();
    chk("R9 casc after first", p_casc, 3'd5);
    chk("R9 casc held", p_casc_after, 3'd5);
    irq_num = 3'd0;
    pulse();
    chk("R9 casc mid", p_casc, 3'd5);
    pulse();
    chk("R9 casc cleared", p_casc_after, 0);
    casc_en = 0; irq_num = 3'd4;
    pulse();
    chk("R9 no master casc", p_casc, 0);
    pulse(); pulse();
  endtask

  task automatic t_slave();
    casc_en = 1; is_slave = 1; slave_id = 3'd4; casc_in = 3'd4;
    mode16 = 0; interval4 = 1; lo_base = 8'hE0; irq_num = 3'd2; hi_base = 8'h55;
    pulse();
    chk("R10 slave no call", p_oe, 0);
    pulse();
    chk("R10 slave match oe", p_oe, 1);
    chk("R10 slave byte", p_data, 8'hE8);
    casc_in = 3'd2;
    pulse();
    chk("R10 slave mismatch", p_oe, 0);
    mode16 = 1; type_base = 8'h08; casc_in = 3'd4;
    pulse(); pulse();
    chk("R10 slave 16 match", p_oe, 1);
    chk("R10 slave 16 byte", p_data, 8'h0A);
    casc_en = 0; is_slave = 0; mode16 = 0;
  endtask

  task automatic t_init();
    mode16 = 0; interval4 = 1; lo_base = 8'h00; irq_num = 3'd3;
    pulse();
    @(negedge clk) init_cmd = 1;
    @(negedge clk) init_cmd = 0;
    pulse();
    chk("R11 restart after init", p_data, 8'hCD);
    chk("R11 oe after init", p_oe, 1);
    chk("R11 freeze after init", p_frz, 1);
    // timing: oe must still be 0 before the first edge that sees ack
    @(negedge clk) ack = 1;
    #1;
    chk("R12 oe before edge", data_oe, 0);
    @(negedge clk);
    chk("R12 oe one clock after", data_oe, 1);
    chk("R3 byte at interval4", data_out, 8'h0C);
    @(negedge clk) ack = 0;
    @(negedge clk);
    chk("R12 oe dropped", data_oe, 0);
  endtask

  initial begin
    t_reset();
    t_8bit_int4();
    t_8bit_int8();
    t_16bit();
    t_mode_change();
    t_master();
    t_slave();
    do_reset();
    t_init();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule